// File: doc/BRIEF.md
# Sorting Network with Duplicate Trap and Concentrator

This block takes a set of N cells, one per input port, each with a valid flag and a destination tag. It returns them in a form a self-routing banyan fabric can carry without internal collisions. A pipelined odd-even merge sorting network puts the valid cells in ascending tag order, and every empty slot goes to the end of the list. A trap stage then keeps only the first cell of each run of equal destinations. It marks every later cell of that run in a mask indexed by the cell's original input port. A concentrator shifts the surviving cells together so that no gaps remain.

Each cell carries its input-port number through the pipeline. Ties are therefore broken by port order, and every output cell reports where it came from. A new set of cells may be presented on every clock. Each set appears at the outputs after a fixed number of cycles: one per compare-exchange rank, plus one for the trap and one for the concentrator.

Top module: `batcher_trap`

## Requirements
- R1: Valid output cells appear in strictly ascending destination-tag order from slot 0 upward.
- R2: Cells whose in_valid bit is 0 never appear at the outputs. The number of valid outputs equals the number of distinct tags among the valid inputs.
- R3: Among valid inputs that share a tag, only the one on the lowest-numbered port survives. Every other such input sets trap_mask[p] to 1, where p is its input port. trap_mask bits of survivors and of invalid inputs are 0.
- R4: The surviving cells fill output slots 0..M-1 with no gaps, so out_valid always reads as a run of ones starting at bit 0. Invalid output slots carry tag 0 and port 0.
- R5: out_port of each valid output slot gives the input port the cell entered on. Slot i of a flat bus occupies bits [i*W +: W].
- R6: A cell set sampled at a clock edge appears at the outputs after log2(N)*(log2(N)+1)/2 + 2 edges (8 for N = 8). Sets may be presented back to back on every cycle.
- R7: While rst is high, out_valid and trap_mask are all zero.
- R8: The tag on an invalid input slot has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-port cell present flag |
| in_tag | input | N*TAG_W | Per-port destination tag, port i at [i*TAG_W +: TAG_W] |
| out_valid | output | N | Per-slot valid flag of the compacted list |
| out_tag | output | N*TAG_W | Per-slot destination tag |
| out_port | output | N*IDX_W | Per-slot original input port |
| trap_mask | output | N | Trapped duplicates, bit p for input port p |

## Verification
The bench builds the block with its defaults, N = 8 and TAG_W = 3. That gives six compare-exchange ranks and an eight-cycle pipeline, and with eight tag values across eight ports both full collisions and fully distinct sets are easy to reach. Random sets alternate between a narrow tag range, which produces heavy duplication, and the full range. Directed sets cover an all-empty input, all-equal tags, reversed distinct tags, and the same valid pattern with different tags on the empty slots. Sets stream on every cycle, so the pipeline registers of neighbouring sets never mix.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  // Number of compare-exchange ranks for 2**logn inputs.
  function automatic int rank_count(input int logn);
    return (logn * (logn + 1)) / 2;
  endfunction

  // True when position x is the lower end of a compare-exchange pair in the
  // rank that merges blocks of size 2p with partner distance k.
  function automatic bit pair_low(input int x, input int p, input int k, input int n);
    int off;
    off = k % p;
    if (x < off) return 1'b0;
    if (x + k >= n) return 1'b0;
    if (((x - off) % (2 * k)) >= k) return 1'b0;
    return ((x / (2 * p)) == ((x + k) / (2 * p)));
  endfunction

endpackage

// File: rtl/bsort_stage.sv
module bsort_stage import bsort_pkg::*; #(
  parameter int N     = 8,
  parameter int TAG_W = 3,
  parameter int IDX_W = 3,
  parameter int P     = 1,
  parameter int K     = 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N-1:0][1+TAG_W+IDX_W-1:0]      d,
  output logic [N-1:0][1+TAG_W+IDX_W-1:0]      q
);
  localparam int CW = 1 + TAG_W + IDX_W;
  localparam logic [CW-1:0] EMPTY = {1'b1, {(CW-1){1'b0}}};

  // Key is {empty, tag, port}: a plain unsigned compare orders valid cells by
  // tag, then by port, and puts empty slots last.
  for (genvar x = 0; x < N; x++) begin : g_pos
    if (pair_low(x, P, K, N)) begin : g_lo
      always_ff @(posedge clk) begin
        if (rst) q[x] <= EMPTY;
        else     q[x] <= (d[x] > d[x+K]) ? d[x+K] : d[x];
      end
    end else if ((x >= K) && pair_low(x - K, P, K, N)) begin : g_hi
      always_ff @(posedge clk) begin
        if (rst) q[x] <= EMPTY;
        else     q[x] <= (d[x-K] > d[x]) ? d[x-K] : d[x];
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) q[x] <= EMPTY;
        else     q[x] <= d[x];
      end
    end
  end

  logic [N-1:0] d_full, q_full;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      d_full[i] = !d[i][CW-1];
      q_full[i] = !q[i][CW-1];
    end
  end

  AST_STAGE_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(q_full) == $countones($past(d_full)))); // R2

endmodule

// File: rtl/bsort_trap.sv
module bsort_trap #(
  parameter int N     = 8,
  parameter int TAG_W = 3,
  parameter int IDX_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N-1:0][1+TAG_W+IDX_W-1:0]      d,
  output logic [N-1:0][1+TAG_W+IDX_W-1:0]      q,
  output logic [N-1:0]                         mask
);
  localparam int CW = 1 + TAG_W + IDX_W;
  localparam logic [CW-1:0] EMPTY = {1'b1, {(CW-1){1'b0}}};

  logic [N-1:0] dup;
  logic [N-1:0] mask_n;

  // Sorted input: equal tags sit next to each other, lowest port first.
  always_comb begin
    dup    = '0;
    mask_n = '0;
    for (int x = 1; x < N; x++) begin
      dup[x] = !d[x][CW-1] && !d[x-1][CW-1] &&
               (d[x][CW-2 -: TAG_W] == d[x-1][CW-2 -: TAG_W]);
    end
    for (int x = 0; x < N; x++) begin
      if (dup[x]) mask_n[d[x][IDX_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      for (int x = 0; x < N; x++) q[x] <= EMPTY;
    end else begin
      mask <= mask_n;
      for (int x = 0; x < N; x++) q[x] <= dup[x] ? EMPTY : d[x];
    end
  end

  logic [N-1:0] d_full, q_full;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      d_full[i] = !d[i][CW-1];
      q_full[i] = !q[i][CW-1];
    end
  end

  AST_TRAP_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($countones(q_full) + $countones(mask)) == $countones($past(d_full)))); // R3

  AST_TRAP_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    ($countones(mask) <= N - $countones(q_full))); // R3

endmodule

// File: rtl/bsort_compact.sv
module bsort_compact #(
  parameter int N     = 8,
  parameter int TAG_W = 3,
  parameter int IDX_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N-1:0][1+TAG_W+IDX_W-1:0]      d,
  input  logic [N-1:0]                         mask_d,
  output logic [N-1:0]                         out_valid,
  output logic [N*TAG_W-1:0]                   out_tag,
  output logic [N*IDX_W-1:0]                   out_port,
  output logic [N-1:0]                         mask_q
);
  localparam int CW = 1 + TAG_W + IDX_W;
  localparam logic [CW-1:0] EMPTY = {1'b1, {(CW-1){1'b0}}};

  logic [N-1:0][CW-1:0] packed_c;
  logic [IDX_W:0]       cnt;

  // Scatter each surviving cell to the slot given by its running count.
  always_comb begin
    cnt = '0;
    for (int x = 0; x < N; x++) packed_c[x] = EMPTY;
    for (int x = 0; x < N; x++) begin
      if (!d[x][CW-1]) begin
        packed_c[cnt[IDX_W-1:0]] = d[x];
        cnt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_tag   <= '0;
      out_port  <= '0;
      mask_q    <= '0;
    end else begin
      mask_q <= mask_d;
      for (int x = 0; x < N; x++) begin
        out_valid[x]                 <= !packed_c[x][CW-1];
        out_tag[x*TAG_W +: TAG_W]    <= packed_c[x][CW-2 -: TAG_W];
        out_port[x*IDX_W +: IDX_W]   <= packed_c[x][IDX_W-1:0];
      end
    end
  end

  logic [N-1:0] d_full;
  always_comb begin
    for (int i = 0; i < N; i++) d_full[i] = !d[i][CW-1];
  end

  AST_COMPACT_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(out_valid) == $countones($past(d_full)))); // R4

  for (genvar x = 0; x + 1 < N; x++) begin : g_chk
    AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (rst)
      out_valid[x+1] |-> (out_valid[x] &&
        (out_tag[x*TAG_W +: TAG_W] < out_tag[(x+1)*TAG_W +: TAG_W]))); // R1
  end

endmodule

// File: rtl/batcher_trap.sv
module batcher_trap import bsort_pkg::*; #(
  parameter int N     = 8,
  parameter int TAG_W = 3,
  parameter int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       in_valid,
  input  logic [N*TAG_W-1:0] in_tag,
  output logic [N-1:0]       out_valid,
  output logic [N*TAG_W-1:0] out_tag,
  output logic [N*IDX_W-1:0] out_port,
  output logic [N-1:0]       trap_mask
);
  localparam int CW     = 1 + TAG_W + IDX_W;
  localparam int LOGN   = $clog2(N);
  localparam int RANKS  = rank_count(LOGN);

  logic [N-1:0][CW-1:0] stg [RANKS+1];
  logic [N-1:0][CW-1:0] trapped_c;
  logic [N-1:0]         mask_t;

  // Empty slots get tag 0 so their input tag cannot influence anything.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      stg[0][i] = {!in_valid[i],
                   in_valid[i] ? in_tag[i*TAG_W +: TAG_W] : {TAG_W{1'b0}},
                   IDX_W'(i)};
    end
  end

  for (genvar lp = 0; lp < LOGN; lp++) begin : g_merge
    for (genvar lk = lp; lk >= 0; lk--) begin : g_rank
      localparam int S = (lp * (lp + 1)) / 2 + (lp - lk);
      bsort_stage #(
        .N(N), .TAG_W(TAG_W), .IDX_W(IDX_W), .P(1 << lp), .K(1 << lk)
      ) u_stage (
        .clk(clk), .rst(rst), .d(stg[S]), .q(stg[S+1])
      );
    end
  end

  bsort_trap #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_trap (
    .clk(clk), .rst(rst), .d(stg[RANKS]), .q(trapped_c), .mask(mask_t)
  );

  bsort_compact #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_compact (
    .clk(clk), .rst(rst), .d(trapped_c), .mask_d(mask_t),
    .out_valid(out_valid), .out_tag(out_tag), .out_port(out_port),
    .mask_q(trap_mask)
  );

  AST_OUT_PACKED: assert property (@(posedge clk) disable iff (rst)
    ((out_valid & (out_valid + 1'b1)) == '0)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && trap_mask == '0)); // R7

endmodule

// File: tb/batcher_trap_tb_top.sv
module batcher_trap_tb_top;
  localparam int N     = 8;
  localparam int TAG_W = 3;
  localparam int IDX_W = 3;
  localparam int LAT   = 8;
  localparam int NV    = 400;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [N-1:0]       in_valid = '0;
  logic [N*TAG_W-1:0] in_tag = '0;
  logic [N-1:0]       out_valid;
  logic [N*TAG_W-1:0] out_tag;
  logic [N*IDX_W-1:0] out_port;
  logic [N-1:0]       trap_mask;

  int errors = 0;
  int checks = 0;

  logic [N-1:0]       vec_v [NV];
  logic [N*TAG_W-1:0] vec_t [NV];

  always #10 clk = ~clk;

  batcher_trap #(.N(N), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .out_valid(out_valid), .out_tag(out_tag), .out_port(out_port),
    .trap_mask(trap_mask)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: stable sort by tag, keep first of each tag, compact.
  task automatic model(input logic [N-1:0] v, input logic [N*TAG_W-1:0] t,
                       output logic [N-1:0] ev, output logic [N*TAG_W-1:0] et,
                       output logic [N*IDX_W-1:0] ep, output logic [N-1:0] em);
    int ord [N];
    int m;
    int cnt;
    m = 0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        int pos;
        pos = m;
        while (pos > 0 && t[ord[pos-1]*TAG_W +: TAG_W] > t[i*TAG_W +: TAG_W]) begin
          ord[pos] = ord[pos-1];
          pos--;
        end
        ord[pos] = i;
        m++;
      end
    end
    ev = '0; et = '0; ep = '0; em = '0; cnt = 0;
    for (int j = 0; j < m; j++) begin
      if (j > 0 && t[ord[j]*TAG_W +: TAG_W] == t[ord[j-1]*TAG_W +: TAG_W]) begin
        em[ord[j]] = 1'b1;
      end else begin
        ev[cnt] = 1'b1;
        et[cnt*TAG_W +: TAG_W] = t[ord[j]*TAG_W +: TAG_W];
        ep[cnt*IDX_W +: IDX_W] = IDX_W'(ord[j]);
        cnt++;
      end
    end
  endtask

  task automatic check_vec(input int n);
    logic [N-1:0]       ev, em;
    logic [N*TAG_W-1:0] et;
    logic [N*IDX_W-1:0] ep;
    model(vec_v[n], vec_t[n], ev, et, ep, em);
    check(out_valid == ev, $sformatf("R2/R4 vec%0d out_valid", n), 64'(out_valid), 64'(ev));
    check(out_tag == et, $sformatf("R1/R6 vec%0d out_tag", n), 64'(out_tag), 64'(et));
    check(out_port == ep, $sformatf("R5 vec%0d out_port", n), 64'(out_port), 64'(ep));
    check(trap_mask == em, $sformatf("R3 vec%0d trap_mask", n), 64'(trap_mask), 64'(em));
    if (n == 0 || n == 5)
      check(out_tag == et && out_valid == ev, $sformatf("R8 vec%0d empty-slot tags", n),
            64'(out_tag), 64'(et));
  endtask

  function automatic logic [N*TAG_W-1:0] tags_of(input int mode);
    logic [N*TAG_W-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: r[i*TAG_W +: TAG_W] = 3'd5;
        1: r[i*TAG_W +: TAG_W] = TAG_W'(N - 1 - i);
        default: r[i*TAG_W +: TAG_W] = (i % 2 == 0) ? 3'd7 : 3'd0;
      endcase
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // directed sets
    vec_v[0] = 8'b0001_0110;
    vec_t[0] = {3'd6, 3'd7, 3'd5, 3'd3, 3'd1, 3'd2, 3'd3, 3'd4};
    vec_v[1] = '0;            vec_t[1] = tags_of(1);
    vec_v[2] = '1;            vec_t[2] = tags_of(0);
    vec_v[3] = '1;            vec_t[3] = tags_of(1);
    vec_v[4] = '1;            vec_t[4] = tags_of(2);
    vec_v[5] = 8'b0001_0110;
    vec_t[5] = {3'd0, 3'd0, 3'd0, 3'd3, 3'd0, 3'd2, 3'd3, 3'd0};
    for (int n = 6; n < NV; n++) begin
      vec_v[n] = N'($urandom);
      for (int i = 0; i < N; i++)
        vec_t[n][i*TAG_W +: TAG_W] = (n % 2 == 0) ? TAG_W'($urandom % 3)
                                                  : TAG_W'($urandom);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0, "R7 reset out_valid", 64'(out_valid), 64'd0);
    check(trap_mask == '0, "R7 reset trap_mask", 64'(trap_mask), 64'd0);
    rst = 1'b0;

    for (int c = 0; c < NV + LAT; c++) begin
      if (c > 0) @(negedge clk);
      if (c >= LAT) check_vec(c - LAT);
      if (c < NV) begin
        in_valid = vec_v[c];
        in_tag   = vec_t[c];
      end else begin
        in_valid = '0;
        in_tag   = '0;
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule